// File: doc/BRIEF.md
# Information-unit CRC32 interval engine

This block protects a packetised transfer on a 16-bit wide data path with a 32-bit CRC. In generate mode it passes each accepted data word to its output and, at the end of a unit, appends two CRC words. When a nonzero interval is programmed, it also appends two CRC words after every interval of data bytes. In check mode it consumes the same stream, with the CRC words in place. At every CRC position it compares the running register with the fixed no-error remainder, and it reports one pass/fail verdict per unit.

The calculation works on the byte stream in transfer order, two bytes per word. Each byte is bit-reversed at its byte boundary before it enters an MSB-first CRC over the polynomial 04C11DB7h. The register is preset to all ones. The finished register is ones-complemented and bit-swapped per byte, then split across the two bus words. Upstream logic must honour `in_ready`, which drops for the two cycles in which a CRC pair is emitted.

Top module: `crcw_iu_engine`

## Requirements
- R1: While and directly after reset, `out_valid`, `unit_done` and `unit_fail` are low and `in_ready` is high.
- R2: In generate mode (`check_mode`=0), a word accepted in cycle k (`in_valid` and `in_ready` high) appears on `out_word` in cycle k+1, with `out_valid`=1 and `out_is_crc`=0.
- R3: Byte order on the bus: bits 7:0 of a word hold the earlier byte and bits 15:8 the later one. Each byte is bit-reversed and then shifted MSB-first through a CRC with polynomial 04C11DB7h, starting from FFFFFFFFh.
- R4: A CRC is sent as the ones-complemented register with the bits of each byte reversed. The first CRC word carries CRC byte 1 on bits 15:8 and CRC byte 0 on bits 7:0, and the second carries CRC bytes 3 and 2. For 32 bytes of 00h, the CRC words are 55ADh then 190Ah. For 32 bytes of FFh, they are AB0Bh then FF6Ch. For the bytes 00h to 1Fh, they are 7E8Ah then 9126h.
- R5: After the word marked `in_last` is accepted in generate mode, the two CRC words appear in cycles k+2 and k+3, and `in_ready` is low in cycles k+1 and k+2.
- R6: `ivl_bytes` gives the interval in bytes. Bit 0 is ignored, so the interval counts whole words. When the interval is nonzero, a CRC pair follows every interval of data words. A unit's last word always closes a segment, and it produces only one CRC pair even when it also completes an interval. When the interval is zero, only the end-of-unit CRC is produced.
- R7: The register is preset to all ones at the start of each unit and after every CRC position, so each CRC covers only the data of its own segment.
- R8: In check mode, the two words after each full interval, and the last two words of a unit, are treated as CRC words. A segment passes only if the register over its data and CRC words equals C704DD7Bh.
- R9: In check mode, `unit_done` pulses for one cycle, in the cycle after the `in_last` word is accepted. `unit_fail` is then high if any segment of that unit failed, and it holds that value until the next `unit_done`.
- R10: In check mode, `out_valid` stays low and `in_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| check_mode | input | 1 | 0 generate, 1 check; held stable for a whole unit |
| ivl_bytes | input | IVLW | CRC interval in bytes, 0 = end of unit only |
| in_valid | input | 1 | Input word valid |
| in_word | input | 16 | Input word, earlier byte in bits 7:0 |
| in_last | input | 1 | Marks the last word of a unit |
| in_ready | output | 1 | Word can be accepted this cycle |
| out_valid | output | 1 | Output word valid (generate mode) |
| out_word | output | 16 | Data word or CRC word |
| out_is_crc | output | 1 | Output word is a CRC word |
| unit_done | output | 1 | One-cycle pulse at the end of a checked unit |
| unit_fail | output | 1 | Verdict of the last checked unit |

## Verification
The bench builds the engine with IVLW=8, which allows intervals of up to 127 words. It drives intervals of 0, 2, 4, 6, 8, 9 and 14 bytes against units of 1 to 20 words. Short intervals therefore bring many CRC positions into one unit, including the case where a unit ends exactly on an interval boundary and the case of an odd interval value. The same streams are fed back in check mode, either intact or with a single flipped bit in a data or CRC word, to reach both verdicts and the sticky failure across later good segments.

// File: rtl/crcw_pkg.sv
package crcw_pkg;
  localparam logic [31:0] CRCW_POLY    = 32'h04C1_1DB7;
  localparam logic [31:0] CRCW_PRESET  = 32'hFFFF_FFFF;
  localparam logic [31:0] CRCW_RESIDUE = 32'hC704_DD7B;

  typedef enum logic [1:0] {
    PH_DATA    = 2'd0,
    PH_TAIL_LO = 2'd1,
    PH_TAIL_HI = 2'd2
  } crcw_phase_e;

  function automatic logic [7:0] bitrev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/crcw_word_step.sv
// One bus word of CRC update: each byte lane is bit-reversed, then lanes are
// shifted in transfer order (lane 0 first), MSB first.
module crcw_word_step
  import crcw_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [31:0]          crc_in,
  input  logic [8*LANES-1:0]   word_in,
  output logic [31:0]          crc_out
);
  logic [7:0] lane_rev [LANES];

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_rev[l] = bitrev8(word_in[8*l +: 8]);
    end
  endgenerate

  always_comb begin
    logic [31:0] c;
    c = crc_in;
    for (int l = 0; l < LANES; l++) begin
      for (int b = 7; b >= 0; b--) begin
        if (c[31] ^ lane_rev[l][b]) c = {c[30:0], 1'b0} ^ CRCW_POLY;
        else                        c = {c[30:0], 1'b0};
      end
    end
    crc_out = c;
  end
endmodule

// File: rtl/crcw_seg_track.sv
// Counts words of the current segment and flags interval boundaries for
// both directions.
module crcw_seg_track #(
  parameter int IVLW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IVLW-1:0] ivl_bytes,
  input  logic            adv,
  input  logic            restart,
  output logic            tx_ivl_end,
  output logic            rx_ivl_end
);
  logic [IVLW-1:0] cnt_q, cnt_d;
  logic [IVLW-1:0] ivl_words;
  logic            ivl_nz;
  logic            cnt_en;
  logic            unused_ivl_lsb;

  assign unused_ivl_lsb = ivl_bytes[0];
  assign ivl_words  = {1'b0, ivl_bytes[IVLW-1:1]};
  assign ivl_nz     = (ivl_words != '0);
  assign tx_ivl_end = ivl_nz && (cnt_q == ivl_words - 1'b1);
  assign rx_ivl_end = ivl_nz && (cnt_q == ivl_words + 1'b1);

  always_comb begin
    cnt_en = restart || adv;
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/crcw_iu_engine.sv
module crcw_iu_engine
  import crcw_pkg::*;
#(
  parameter int IVLW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            check_mode,
  input  logic [IVLW-1:0] ivl_bytes,
  input  logic            in_valid,
  input  logic [15:0]     in_word,
  input  logic            in_last,
  output logic            in_ready,
  output logic            out_valid,
  output logic [15:0]     out_word,
  output logic            out_is_crc,
  output logic            unit_done,
  output logic            unit_fail
);
  localparam int LANES = 2;

  crcw_phase_e phase_q, phase_d;
  logic [31:0] crc_q, crc_d, crc_upd, crc_fin;
  logic        crc_en;
  logic        take, tx_bnd, rx_bnd, rx_bad;
  logic        tx_ivl_end, rx_ivl_end;
  logic [15:0] tail_lo, tail_hi;
  logic        ov_q, ov_d, oc_q, oc_d;
  logic [15:0] ow_q, ow_d;
  logic        sticky_q, sticky_d;
  logic        done_q, done_d, fail_q, fail_d, fail_en;

  crcw_word_step #(.LANES(LANES)) u_step (
    .crc_in  (crc_q),
    .word_in (in_word),
    .crc_out (crc_upd)
  );

  crcw_seg_track #(.IVLW(IVLW)) u_seg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ivl_bytes  (ivl_bytes),
    .adv        (take),
    .restart    (tx_bnd || rx_bnd),
    .tx_ivl_end (tx_ivl_end),
    .rx_ivl_end (rx_ivl_end)
  );

  assign in_ready = (phase_q == PH_DATA);
  assign take     = in_valid && in_ready;
  assign tx_bnd   = take && !check_mode && (in_last || tx_ivl_end);
  assign rx_bnd   = take &&  check_mode && (in_last || rx_ivl_end);
  assign rx_bad   = (crc_upd != CRCW_RESIDUE);

  // Transmitted form: complement, reverse bits inside each byte, low half first.
  assign crc_fin = ~crc_q;
  assign tail_lo = {bitrev8(crc_fin[23:16]), bitrev8(crc_fin[31:24])};
  assign tail_hi = {bitrev8(crc_fin[7:0]),   bitrev8(crc_fin[15:8])};

  // Phase and CRC register next state
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_DATA:    if (tx_bnd) phase_d = PH_TAIL_LO;
      PH_TAIL_LO: phase_d = PH_TAIL_HI;
      PH_TAIL_HI: phase_d = PH_DATA;
      default:    phase_d = PH_DATA;
    endcase

    crc_en = 1'b1;
    if (rx_bnd || phase_q == PH_TAIL_HI) crc_d = CRCW_PRESET;
    else if (take)                       crc_d = crc_upd;
    else begin
      crc_d  = crc_q;
      crc_en = 1'b0;
    end
  end

  // Output stream next state
  always_comb begin
    ov_d = 1'b0;
    oc_d = 1'b0;
    ow_d = ow_q;
    if (phase_q == PH_TAIL_LO) begin
      ov_d = 1'b1; oc_d = 1'b1; ow_d = tail_lo;
    end else if (phase_q == PH_TAIL_HI) begin
      ov_d = 1'b1; oc_d = 1'b1; ow_d = tail_hi;
    end else if (take && !check_mode) begin
      ov_d = 1'b1; ow_d = in_word;
    end
  end

  // Check verdict next state
  always_comb begin
    sticky_d = sticky_q;
    done_d   = rx_bnd && in_last;
    fail_en  = done_d;
    fail_d   = sticky_q || rx_bad;
    if (rx_bnd) sticky_d = in_last ? 1'b0 : (sticky_q || rx_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_DATA;
      crc_q    <= CRCW_PRESET;
      ov_q     <= 1'b0;
      oc_q     <= 1'b0;
      ow_q     <= '0;
      sticky_q <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      if (crc_en)  crc_q <= crc_d;
      ov_q     <= ov_d;
      oc_q     <= oc_d;
      if (ov_d)    ow_q <= ow_d;
      sticky_q <= sticky_d;
      done_q   <= done_d;
      if (fail_en) fail_q <= fail_d;
    end
  end

  assign out_valid  = ov_q;
  assign out_word   = ow_q;
  assign out_is_crc = oc_q;
  assign unit_done  = done_q;
  assign unit_fail  = fail_q;
endmodule

// File: rtl/crcw_iu_engine_chk.sv
module crcw_iu_engine_chk #(
  parameter int IVLW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            check_mode,
  input logic [IVLW-1:0] ivl_bytes,
  input logic            in_valid,
  input logic [15:0]     in_word,
  input logic            in_last,
  input logic            in_ready,
  input logic            out_valid,
  input logic [15:0]     out_word,
  input logic            out_is_crc,
  input logic            unit_done,
  input logic            unit_fail
);
  logic unused_ivl;
  assign unused_ivl = ^ivl_bytes;

  p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !check_mode) |=>
      (out_valid && !out_is_crc && out_word == $past(in_word)));

  p_tail_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !check_mode && in_last) |=> !in_ready ##1 !in_ready);

  p_tail_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !check_mode && in_last) |=>
      ##1 (out_valid && out_is_crc) ##1 (out_valid && out_is_crc));

  p_done_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |-> $past(in_valid && in_ready && in_last && check_mode));

  p_fail_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_done |-> $stable(unit_fail));

  p_rx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (check_mode && in_ready) |=> !out_valid);
endmodule

bind crcw_iu_engine crcw_iu_engine_chk #(.IVLW(IVLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .check_mode(check_mode), .ivl_bytes(ivl_bytes),
  .in_valid(in_valid), .in_word(in_word), .in_last(in_last), .in_ready(in_ready),
  .out_valid(out_valid), .out_word(out_word), .out_is_crc(out_is_crc),
  .unit_done(unit_done), .unit_fail(unit_fail)
);

// File: tb/crcw_iu_engine_tb.sv
module crcw_iu_engine_tb;
  localparam int IVLW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            check_mode;
  logic [IVLW-1:0] ivl_bytes;
  logic            in_valid;
  logic [15:0]     in_word;
  logic            in_last;
  logic            in_ready, out_valid, out_is_crc, unit_done, unit_fail;
  logic [15:0]     out_word;

  int n_vec = 0;
  int n_bad = 0;

  logic [15:0] unit_w[$];
  logic [15:0] exp_w[$];
  logic        exp_c[$];
  logic [15:0] drv_w[$];
  logic [15:0] obs_w[$];
  logic        obs_c[$];
  logic        obs_f[$];

  always #10 clk = ~clk;

  crcw_iu_engine #(.IVLW(IVLW)) u_dut (
    .clk(clk), .rst_n(rst_n), .check_mode(check_mode), .ivl_bytes(ivl_bytes),
    .in_valid(in_valid), .in_word(in_word), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_word(out_word), .out_is_crc(out_is_crc),
    .unit_done(unit_done), .unit_fail(unit_fail)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        obs_w.push_back(out_word);
        obs_c.push_back(out_is_crc);
      end
      if (unit_done) obs_f.push_back(unit_fail);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reflected form of the same CRC: feeding bytes LSB first equals per-byte swap.
  function automatic logic [31:0] ref_byte(input logic [31:0] r, input logic [7:0] b);
    logic [31:0] c;
    c = r;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB8_8320;
      else             c = c >> 1;
    end
    return c;
  endfunction

  // Expected generate-mode stream for unit_w with an interval of ivlw words.
  task automatic build_exp(input int ivlw);
    logic [31:0] r;
    int cnt;
    r = 32'hFFFF_FFFF;
    cnt = 0;
    exp_w.delete();
    exp_c.delete();
    for (int i = 0; i < unit_w.size(); i++) begin
      exp_w.push_back(unit_w[i]);
      exp_c.push_back(1'b0);
      r = ref_byte(ref_byte(r, unit_w[i][7:0]), unit_w[i][15:8]);
      cnt++;
      if (i == unit_w.size() - 1 || (ivlw != 0 && cnt == ivlw)) begin
        exp_w.push_back(~r[15:0]);
        exp_c.push_back(1'b1);
        exp_w.push_back(~r[31:16]);
        exp_c.push_back(1'b1);
        r = 32'hFFFF_FFFF;
        cnt = 0;
      end
    end
  endtask

  task automatic drive_stream();
    for (int i = 0; i < drv_w.size(); i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_word  = drv_w[i];
      in_last  = (i == drv_w.size() - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run_tx(input int ivl_b);
    check_mode = 1'b0;
    ivl_bytes  = IVLW'(ivl_b);
    build_exp(ivl_b >> 1);
    obs_w.delete(); obs_c.delete();
    drv_w = unit_w;
    drive_stream();
    chk("R5 in_ready low tail cycle 1", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R5 in_ready low tail cycle 2", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R5 in_ready back high", 32'(in_ready), 32'd1);
    repeat (2) @(negedge clk);
    chk("R2 R6 stream length", 32'(obs_w.size()), 32'(exp_w.size()));
    for (int i = 0; i < exp_w.size() && i < obs_w.size(); i++) begin
      chk("R3 R4 R6 R7 word", 32'(obs_w[i]), 32'(exp_w[i]));
      chk("R2 R6 crc flag", 32'(obs_c[i]), 32'(exp_c[i]));
    end
  endtask

  task automatic run_rx(input int ivl_b, input int bad_idx);
    check_mode = 1'b1;
    ivl_bytes  = IVLW'(ivl_b);
    build_exp(ivl_b >> 1);
    drv_w = exp_w;
    if (bad_idx >= 0) drv_w[bad_idx] = drv_w[bad_idx] ^ 16'h0100;
    obs_w.delete(); obs_c.delete(); obs_f.delete();
    drive_stream();
    chk("R9 unit_done pulse", 32'(unit_done), 32'd1);
    @(negedge clk);
    chk("R9 unit_done single cycle", 32'(unit_done), 32'd0);
    repeat (2) @(negedge clk);
    chk("R9 one verdict", 32'(obs_f.size()), 32'd1);
    if (obs_f.size() == 1)
      chk("R8 R9 verdict", 32'(obs_f[0]), (bad_idx >= 0) ? 32'd1 : 32'd0);
    chk("R9 verdict held", 32'(unit_fail), (bad_idx >= 0) ? 32'd1 : 32'd0);
    chk("R10 no output words", 32'(obs_w.size()), 32'd0);
    chk("R10 in_ready high", 32'(in_ready), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7031));
    rst_n = 1'b0; check_mode = 1'b0; ivl_bytes = '0;
    in_valid = 1'b0; in_word = '0; in_last = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 unit_done", 32'(unit_done), 32'd0);
    chk("R1 unit_fail", 32'(unit_fail), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);

    // R4 fixed vectors, end-only CRC
    unit_w.delete();
    for (int i = 0; i < 16; i++) unit_w.push_back(16'h0000);
    run_tx(0);
    if (obs_w.size() == 18) begin
      chk("R4 zeros word 1", 32'(obs_w[16]), 32'h55AD);
      chk("R4 zeros word 2", 32'(obs_w[17]), 32'h190A);
    end
    unit_w.delete();
    for (int i = 0; i < 16; i++) unit_w.push_back(16'hFFFF);
    run_tx(0);
    if (obs_w.size() == 18) begin
      chk("R4 ones word 1", 32'(obs_w[16]), 32'hAB0B);
      chk("R4 ones word 2", 32'(obs_w[17]), 32'hFF6C);
    end
    unit_w.delete();
    for (int i = 0; i < 16; i++) unit_w.push_back({8'(2*i+1), 8'(2*i)});
    run_tx(0);
    if (obs_w.size() == 18) begin
      chk("R3 R4 ramp word 1", 32'(obs_w[16]), 32'h7E8A);
      chk("R3 R4 ramp word 2", 32'(obs_w[17]), 32'h9126);
    end

    // R6 R7 interval 8 bytes, unit ends on a boundary, then odd interval 9
    unit_w.delete();
    for (int i = 0; i < 12; i++) unit_w.push_back(16'($urandom));
    run_tx(8);
    run_tx(9);
    unit_w.delete();
    for (int i = 0; i < 10; i++) unit_w.push_back(16'($urandom));
    run_tx(8);

    // R8 R9 check mode: clean, corrupt data in first segment, corrupt CRC word
    run_rx(8, -1);
    run_rx(8, 1);
    run_rx(8, 4);
    run_rx(0, -1);
    run_rx(0, 11);

    for (int u = 0; u < 40; u++) begin
      int len, ivs, sel;
      len = 1 + int'($urandom % 20);
      sel = int'($urandom % 7);
      ivs = (sel == 0) ? 0 : (sel == 1) ? 2 : (sel == 2) ? 4 : (sel == 3) ? 6 :
            (sel == 4) ? 8 : (sel == 5) ? 9 : 14;
      unit_w.delete();
      for (int i = 0; i < len; i++) unit_w.push_back(16'($urandom));
      if ($urandom % 2 == 0) run_tx(ivs);
      else begin
        build_exp(ivs >> 1);
        if ($urandom % 2 == 0) run_rx(ivs, -1);
        else run_rx(ivs, int'($urandom % exp_w.size()));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule